// File: doc/BRIEF.md
# Four-Phase Floating-Point Charge Encoder

This block is the digital back end of a charge digitizer that never pauses. On every clock period it accepts one unsigned linear charge sample, counted in units of the finest bin. It returns one 8-bit code that follows a two-level logarithmic format. A 2-bit range exponent picks one of four gain ranges, and each range is eight times coarser than the one below it. A 6-bit mantissa is split into four sections, and the bin width doubles from each section to the next. Together they give sixteen effective ranges over roughly 17 bits of linear input.

Four interleaved phases share the work. Each sample moves through a clear slot, a hold slot where a per-phase pedestal offset is added, a range-choice slot and a quantize slot. Every stage is registered, so a new code leaves the block every period. Each code carries the 2-bit identifier of the phase that produced it, and the identifier stays aligned with that code. The pedestal table has one signed entry per phase. It lets the four phases be trimmed so that they agree.

Top module: `qfp_encoder`

## Requirements
- R1: While reset is high, and for the first three periods after it falls, `out_code` and `out_phase` are both 0. Reset also clears all four pedestal entries to 0.
- R2: The first sample presented in the period in which reset falls gets phase identifier 0. Each later sample gets the next identifier, counting modulo 4.
- R3: The code for a sample presented before clock edge k appears on the outputs just after edge k+3, which is four registers of latency. `out_phase` leaves the block on the same cycle as the code it labels.
- R4: The code is laid out as exponent in bits [7:6] and mantissa in bits [5:0]. The adjusted sample q selects range r, the smallest r in 0..3 for which floor(q / 8^r) < 240. The value passed to the mantissa stage is s = floor(q / 8^r).
- R5: The mantissa is built from s as follows. For s in 0..15, m = s. For s in 16..47, m = 16 + floor((s-16)/2). For s in 48..111, m = 32 + floor((s-48)/4). For s in 112..239, m = 48 + floor((s-112)/8).
- R6: Any adjusted sample of 122880 or more produces the all-ones code 0xFF.
- R7: The adjusted sample is the input plus the signed 8-bit two's-complement pedestal of its phase. Results below 0 are clamped to 0, and results above 131071 are clamped to 131071.
- R8: A pedestal write is stored at the clock edge that ends its period. It already applies to the sample presented in that same period when that sample's phase matches. It does not affect a sample presented one period earlier. Later samples of the written phase use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per period |
| rst | input | 1 | Synchronous active-high reset |
| in_sample | input | 17 | Unsigned linear charge sample in finest-bin units |
| ped_wr_en | input | 1 | Pedestal write strobe |
| ped_wr_phase | input | 2 | Phase whose pedestal is written |
| ped_wr_value | input | 8 | Signed two's-complement pedestal value |
| out_code | output | 8 | Exponent [7:6] and mantissa [5:0] |
| out_phase | output | 2 | Phase identifier of the code on `out_code` |

## Verification
A pedestal write and the sample of the same phase can meet in the hold stage in the same cycle. The bench provokes this in two ways. In the first, the write is issued in the same period as a sample of the target phase, and the new offset must already shift that sample. In the second, the write is issued one period after a sample of the target phase, and the old offset must still reach that sample while the next sample of the phase picks up the new one. Each outcome is judged from the code that leaves the block four cycles later. The expected values are worked out by hand from the section and range formulas.

// File: rtl/qfp_pkg.sv
package qfp_pkg;

  // The rotating pipeline always has four stages, hence four phases.
  localparam int N_PHASE = 4;
  localparam int PH_W    = 2;

  // Lowest input value that falls in mantissa section sec.
  function automatic int sect_base(input int sec, input int sect_codes);
    return sect_codes * ((1 << sec) - 1);
  endfunction

  // Number of input units covered by one full range.
  function automatic int full_scale(input int n_sect, input int sect_codes);
    return sect_codes * ((1 << n_sect) - 1);
  endfunction

  // Mantissa code for a scaled value; used to derive checker constants.
  function automatic int mant_code(input int s, input int sect_bits, input int n_sect);
    int sec;
    sec = 0;
    for (int i = 1; i < n_sect; i++) begin
      if (s >= sect_base(i, 1 << sect_bits)) sec = i;
    end
    return sec * (1 << sect_bits) + ((s - sect_base(sec, 1 << sect_bits)) >> sec);
  endfunction

endpackage

// File: rtl/qfp_phase_seq.sv
module qfp_phase_seq #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

endmodule

// File: rtl/qfp_ped_store.sv
module qfp_ped_store #(
  parameter int N_PHASE = 4,
  parameter int PH_W    = 2,
  parameter int PED_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PH_W-1:0]  wr_phase,
  input  logic [PED_W-1:0] wr_value,
  input  logic [PH_W-1:0]  rd_phase,
  output logic [PED_W-1:0] rd_value
);

  // Small distributed table, read asynchronously by the hold stage.
  logic [PED_W-1:0] ped_mem [N_PHASE];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_PHASE; i++) ped_mem[i] <= '0;
    end else if (wr_en) begin
      ped_mem[wr_phase] <= wr_value;
    end
  end

  assign rd_value = ped_mem[rd_phase];

endmodule

// File: rtl/qfp_range_sel.sv
module qfp_range_sel #(
  parameter int SAMPLE_W    = 17,
  parameter int EXP_W       = 2,
  parameter int RANGE_SHIFT = 3,
  parameter int FS          = 240,
  parameter int SCALE_W     = 8
) (
  input  logic [SAMPLE_W-1:0] q,
  output logic [EXP_W-1:0]    exp_sel,
  output logic [SCALE_W-1:0]  scaled
);

  localparam int N_RANGE = 1 << EXP_W;

  logic [SAMPLE_W-1:0] shifted [N_RANGE];
  logic [N_RANGE-1:0]  fits;

  // One scaled copy and one fit test per range, evaluated in parallel.
  for (genvar r = 0; r < N_RANGE; r++) begin : g_range
    assign shifted[r] = q >> (r * RANGE_SHIFT);
    assign fits[r]    = shifted[r] < SAMPLE_W'(FS);
  end

  // Lowest fitting range wins; nothing fitting means saturate the top range.
  always_comb begin
    exp_sel = '1;
    scaled  = SCALE_W'(FS - 1);
    for (int r = N_RANGE - 1; r >= 0; r--) begin
      if (fits[r]) begin
        exp_sel = EXP_W'(r);
        scaled  = shifted[r][SCALE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/qfp_mant_quant.sv
module qfp_mant_quant #(
  parameter int SCALE_W   = 8,
  parameter int MANT_W    = 6,
  parameter int SECT_BITS = 4
) (
  input  logic [SCALE_W-1:0] s,
  output logic [MANT_W-1:0]  mant
);

  localparam int SEC_W      = MANT_W - SECT_BITS;
  localparam int N_SECT     = 1 << SEC_W;
  localparam int SECT_CODES = 1 << SECT_BITS;

  logic [N_SECT-1:0] above;
  logic [MANT_W-1:0] cand [N_SECT];

  // Each section subtracts its base and drops as many low bits as its width doubles.
  for (genvar i = 0; i < N_SECT; i++) begin : g_sect
    localparam int BASE = qfp_pkg::sect_base(i, SECT_CODES);
    logic [SCALE_W-1:0] diff;
    logic [SCALE_W-1:0] off;
    if (i == 0) begin : g_first
      assign above[i] = 1'b1;
    end else begin : g_rest
      assign above[i] = s >= SCALE_W'(BASE);
    end
    assign diff    = s - SCALE_W'(BASE);
    assign off     = diff >> i;
    assign cand[i] = {SEC_W'(i), off[SECT_BITS-1:0]};
  end

  always_comb begin
    mant = cand[0];
    for (int i = 1; i < N_SECT; i++) begin
      if (above[i]) mant = cand[i];
    end
  end

endmodule

// File: rtl/qfp_encoder.sv
module qfp_encoder #(
  parameter int SAMPLE_W    = 17,
  parameter int EXP_W       = 2,
  parameter int MANT_W      = 6,
  parameter int SECT_BITS   = 4,
  parameter int RANGE_SHIFT = 3,
  parameter int PED_W       = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SAMPLE_W-1:0]     in_sample,
  input  logic                    ped_wr_en,
  input  logic [1:0]              ped_wr_phase,
  input  logic [PED_W-1:0]        ped_wr_value,
  output logic [EXP_W+MANT_W-1:0] out_code,
  output logic [1:0]              out_phase
);

  localparam int PH_W    = qfp_pkg::PH_W;
  localparam int N_PHASE = qfp_pkg::N_PHASE;
  localparam int CODE_W  = EXP_W + MANT_W;
  localparam int N_SECT  = 1 << (MANT_W - SECT_BITS);
  localparam int FS      = qfp_pkg::full_scale(N_SECT, 1 << SECT_BITS);
  localparam int SCALE_W = $clog2(FS);
  localparam int TOP_Q   = FS << (RANGE_SHIFT * ((1 << EXP_W) - 1));
  localparam int MIN_MANT = qfp_pkg::mant_code(FS >> RANGE_SHIFT, SECT_BITS, N_SECT);
  localparam int SUM_W   = SAMPLE_W + 2;

  // Phase counter feeding the clear stage.
  logic [PH_W-1:0] cur_phase;

  qfp_phase_seq #(.PH_W(PH_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .phase (cur_phase)
  );

  // Stage 0: clear slot, the sample and its phase are captured.
  logic [SAMPLE_W-1:0] s0_q;
  logic [PH_W-1:0]     s0_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_q  <= '0;
      s0_ph <= '0;
    end else begin
      s0_q  <= in_sample;
      s0_ph <= cur_phase;
    end
  end

  // Stage 1: hold slot, the pedestal of the sample's phase is added.
  logic [PED_W-1:0]    ped_rd;
  logic [SUM_W-1:0]    ped_sum;
  logic [SAMPLE_W-1:0] adj_q;
  logic [SAMPLE_W-1:0] s1_q;
  logic [PH_W-1:0]     s1_ph;

  qfp_ped_store #(
    .N_PHASE (N_PHASE),
    .PH_W    (PH_W),
    .PED_W   (PED_W)
  ) u_ped (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ped_wr_en),
    .wr_phase (ped_wr_phase),
    .wr_value (ped_wr_value),
    .rd_phase (s0_ph),
    .rd_value (ped_rd)
  );

  always_comb begin
    ped_sum = {2'b00, s0_q} + {{(SUM_W - PED_W){ped_rd[PED_W-1]}}, ped_rd};
    if (ped_sum[SUM_W-1])       adj_q = '0;
    else if (ped_sum[SAMPLE_W]) adj_q = '1;
    else                        adj_q = ped_sum[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= '0;
      s1_ph <= '0;
    end else begin
      s1_q  <= adj_q;
      s1_ph <= s0_ph;
    end
  end

  // Stage 2: range choice.
  logic [EXP_W-1:0]   rs_exp;
  logic [SCALE_W-1:0] rs_scaled;
  logic [EXP_W-1:0]   s2_exp;
  logic [SCALE_W-1:0] s2_scaled;
  logic [PH_W-1:0]    s2_ph;

  qfp_range_sel #(
    .SAMPLE_W    (SAMPLE_W),
    .EXP_W       (EXP_W),
    .RANGE_SHIFT (RANGE_SHIFT),
    .FS          (FS),
    .SCALE_W     (SCALE_W)
  ) u_range (
    .q       (s1_q),
    .exp_sel (rs_exp),
    .scaled  (rs_scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_exp    <= '0;
      s2_scaled <= '0;
      s2_ph     <= '0;
    end else begin
      s2_exp    <= rs_exp;
      s2_scaled <= rs_scaled;
      s2_ph     <= s1_ph;
    end
  end

  // Stage 3: quantize into the sectioned mantissa, registered at the port.
  logic [MANT_W-1:0] mq_mant;

  qfp_mant_quant #(
    .SCALE_W   (SCALE_W),
    .MANT_W    (MANT_W),
    .SECT_BITS (SECT_BITS)
  ) u_mant (
    .s    (s2_scaled),
    .mant (mq_mant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_code  <= '0;
      out_phase <= '0;
    end else begin
      out_code  <= {s2_exp, mq_mant};
      out_phase <= s2_ph;
    end
  end

endmodule

// File: rtl/qfp_encoder_chk.sv
module qfp_encoder_chk #(
  parameter int SAMPLE_W = 17,
  parameter int EXP_W    = 2,
  parameter int MANT_W   = 6,
  parameter int TOP_Q    = 122880,
  parameter int MIN_MANT = 23
) (
  input logic                    clk,
  input logic                    rst,
  input logic [EXP_W+MANT_W-1:0] out_code,
  input logic [1:0]              out_phase,
  input logic [SAMPLE_W-1:0]     s1_q
);

  localparam int CODE_W = EXP_W + MANT_W;

  logic [2:0] primed;
  logic [1:0] exp_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= '0;
      exp_ph <= '0;
    end else begin
      exp_ph <= exp_ph + 1'b1;
      if (primed != 3'd4) primed <= primed + 1'b1;
    end
  end

  // R1
  reset_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (primed < 3'd4) |-> (out_code == '0 && out_phase == '0));

  // R2
  phase_rotation_chk: assert property (@(posedge clk) disable iff (rst)
    (primed == 3'd4) |-> (out_phase == exp_ph));

  // R4
  range_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (out_code[CODE_W-1 -: EXP_W] != '0) |-> (out_code[MANT_W-1:0] >= MANT_W'(MIN_MANT)));

  // R6
  top_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    ((primed >= 3'd2) && ($past(s1_q, 2) >= SAMPLE_W'(TOP_Q))) |-> (&out_code));

endmodule

bind qfp_encoder qfp_encoder_chk #(
  .SAMPLE_W (SAMPLE_W),
  .EXP_W    (EXP_W),
  .MANT_W   (MANT_W),
  .TOP_Q    (TOP_Q),
  .MIN_MANT (MIN_MANT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_code  (out_code),
  .out_phase (out_phase),
  .s1_q      (s1_q)
);

// File: tb/qfp_encoder_bench.sv
module qfp_encoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 17;
  localparam int WATCHDOG = 20000;
  localparam int N_VEC = 18;

  // {sample, expected code} with all pedestals at zero
  localparam logic [24:0] VEC [N_VEC] = '{
    {17'd0,      8'h00}, {17'd15,     8'h0F}, {17'd16,     8'h10},
    {17'd17,     8'h10}, {17'd47,     8'h1F}, {17'd48,     8'h20},
    {17'd111,    8'h2F}, {17'd112,    8'h30}, {17'd239,    8'h3F},
    {17'd240,    8'h57}, {17'd1000,   8'h71}, {17'd1919,   8'h7F},
    {17'd1920,   8'h97}, {17'd15359,  8'hBF}, {17'd15360,  8'hD7},
    {17'd122879, 8'hFF}, {17'd122880, 8'hFF}, {17'd131071, 8'hFF}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] in_sample = '0;
  logic          ped_wr_en = 1'b0;
  logic [1:0]    ped_wr_phase = '0;
  logic [7:0]    ped_wr_value = '0;
  logic [7:0]    out_code;
  logic [1:0]    out_phase;

  int    n_chk = 0;
  int    n_fail = 0;
  int    n_drv = 0;
  logic [7:0] exp_a [64];
  logic       chk_a [64];
  string      tag_a [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  qfp_encoder u_qfp_encoder (
    .clk          (clk),
    .rst          (rst),
    .in_sample    (in_sample),
    .ped_wr_en    (ped_wr_en),
    .ped_wr_phase (ped_wr_phase),
    .ped_wr_value (ped_wr_value),
    .out_code     (out_code),
    .out_phase    (out_phase)
  );

  task automatic compare(input logic [7:0] exp_code, input logic [1:0] exp_ph, input string tag);
    n_chk++;
    if (out_code !== exp_code || out_phase !== exp_ph) begin
      n_fail++;
      $display("FAIL %s/R3 code %h expected %h, phase %0d expected %0d (R2)",
               tag, out_code, exp_code, out_phase, exp_ph);
    end
  endtask

  // Presents one sample per period and checks the code of the sample four periods back.
  task automatic drive(input logic [SW-1:0] q, input logic [7:0] exp_code, input logic chk,
                       input string tag, input logic we, input logic [1:0] wph,
                       input logic [7:0] wval);
    @(negedge clk);
    if (n_drv >= 4) begin
      if (chk_a[n_drv-4]) compare(exp_a[n_drv-4], 2'(n_drv - 4), tag_a[n_drv-4]);
    end else if (n_drv > 0) begin
      compare(8'h00, 2'd0, "R1 flush");
    end
    rst          = 1'b0;
    in_sample    = q;
    ped_wr_en    = we;
    ped_wr_phase = wph;
    ped_wr_value = wval;
    exp_a[n_drv] = exp_code;
    chk_a[n_drv] = chk;
    tag_a[n_drv] = tag;
    n_drv++;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) drive('0, 8'h00, 1'b0, "", 1'b0, 2'd0, 8'h00);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst       = 1'b1;
    in_sample = '0;
    ped_wr_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(8'h00, 2'd0, "R1 reset");
    n_drv = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R3 actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();

    // R4 R5 R6 boundaries of every section and range, phases rotate (R2)
    for (int i = 0; i < N_VEC; i++)
      drive(VEC[i][24:8], VEC[i][7:0], 1'b1, "R4 R5 R6 table", 1'b0, 2'd0, 8'h00);

    // n=18 ph2; write +20 to phase 3
    drive(17'd5,      8'h05, 1'b1, "R7 other phase untouched", 1'b1, 2'd3, 8'h14);
    // n=19 ph3: 0+20 -> 20
    drive(17'd0,      8'h12, 1'b1, "R7 positive offset",       1'b0, 2'd0, 8'h00);
    // n=20 ph0; write -5 to phase 1
    drive(17'd7,      8'h07, 1'b1, "R7 zero pedestal",         1'b1, 2'd1, 8'hFB);
    // n=21 ph1: 3-5 -> clamp 0
    drive(17'd3,      8'h00, 1'b1, "R7 low clamp",             1'b0, 2'd0, 8'h00);
    // n=22 ph2: same-cycle write +100, 100+100 -> 200
    drive(17'd100,    8'h3B, 1'b1, "R8 same-cycle write",      1'b1, 2'd2, 8'h64);
    // n=23 ph3: still +20
    drive(17'd0,      8'h12, 1'b1, "R8 old value kept",        1'b0, 2'd0, 8'h00);
    // n=24 ph0; write -20 to phase 3 one period after its sample
    drive(17'd0,      8'h00, 1'b1, "R8 late write",            1'b1, 2'd3, 8'hEC);
    // n=25 ph1: 130000-5 above top
    drive(17'd130000, 8'hFF, 1'b1, "R6 saturate",              1'b0, 2'd0, 8'h00);
    // n=26 ph2: 131071+100 -> clamp 131071
    drive(17'd131071, 8'hFF, 1'b1, "R7 high clamp",            1'b0, 2'd0, 8'h00);
    // n=27 ph3: 40-20 -> 20
    drive(17'd40,     8'h12, 1'b1, "R8 new value used",        1'b0, 2'd0, 8'h00);
    // n=28 ph0
    drive(17'd16,     8'h10, 1'b1, "R5 section edge",          1'b0, 2'd0, 8'h00);
    flush();

    // Reset clears pedestals: every phase passes the sample unchanged (R1)
    do_reset();
    for (int i = 0; i < 4; i++)
      drive(17'd5, 8'h05, 1'b1, "R1 pedestals cleared", 1'b0, 2'd0, 8'h00);
    flush();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule